// File: doc/BRIEF.md
# Light-Load Diode Emulation and Pulse-Skip Watchdog

This block sits between the PWM modulator of a synchronous buck converter and the low-side gate driver. At light load the inductor current can reverse while the low-side switch is on. The block therefore gates the low-side command off as soon as a switch-node comparator reports a zero crossing. It keeps that switch off for the rest of the switching cycle, so the converter behaves as if it had a diode and runs in discontinuous conduction.

A trim unit sets the comparator threshold from one switching cycle to the next. After each emulated turn-off it waits for the low-side gate to drop below 1 V. It then ignores a blanking interval, reads a body-diode-conduction flag once, and moves a signed trim code one step in whichever direction shortens body-diode conduction.

A watchdog timer runs while no high-side pulse is present. If pulses stop for long enough that the switching frequency would fall into the audio band, the timer forces a short low-side pulse, which discharges the output and lets the loop start the next burst.

Top module: `lldem_ctrl`

States of the switching FSM are IDLE, HIGH, LOW, CUT and FORCE. Its transitions are as follows:
- Any state goes to HIGH whenever `hs_req` is high.
- IDLE goes to FORCE on a timer expiry. Otherwise IDLE goes to LOW when `ls_req` is high.
- HIGH goes to LOW or to IDLE when `hs_req` falls, depending on `ls_req`.
- LOW goes to CUT on a zero crossing, or to IDLE when `ls_req` drops.
- CUT goes to FORCE on expiry, or to IDLE when `ls_req` drops.
- FORCE goes back to IDLE after its programmed length.

The trim unit has four states. It goes from WAIT to GATE on every exit from LOW. It goes from GATE to BLANK when the gate-low flag is seen, from BLANK to CAPT after the blanking count, and from CAPT back to WAIT.

## Requirements
- R1: Out of reset `ls_cmd` is 0 and `trim_code` holds the initial set point +1 (two's complement, 1 mV per step).
- R2: In the cycle after any clock edge at which `hs_req` is high, `ls_cmd` is 0, whatever the other inputs are.
- R3: With no high-side request and no zero crossing, `ls_cmd` rises one cycle after `ls_req` rises and falls one cycle after `ls_req` falls.
- R4: When `zc_trip` is seen while the low side is conducting on request, `ls_cmd` goes to 0 in the next cycle and stays 0 while `ls_req` remains high, until a new high-side request arrives.
- R5: After the first high-side pulse since reset, when `hs_req` stays low for TIMEOUT_CYC consecutive edges, `ls_cmd` is forced high in the cycle after the TIMEOUT_CYC-th such edge.
- R6: A forced low-side pulse lasts exactly FORCE_CYC cycles, and `zc_trip` has no effect on it.
- R7: A high-side request during a forced pulse ends it, with `ls_cmd` at 0 in the next cycle.
- R8: Each high-side pulse restarts the watchdog, so pulses spaced closer than TIMEOUT_CYC cycles never produce a forced pulse.
- R9: After each emulated turn-off, a captured body-diode flag of 1 raises `trim_code` by one, and a flag of 0 lowers it by one. The code never changes by more than one step per cycle.
- R10: The body-diode flag is ignored for the BLANK_CYC cycles that follow the first edge at which `lg_low` is seen high. It is sampled at the single edge after that interval.
- R11: `trim_code` saturates at +15 and at -16 and never wraps.
- R12: Before the first high-side pulse after reset, the watchdog never forces `ls_cmd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 1 | High-side gate request from the PWM modulator |
| ls_req | input | 1 | Low-side gate request from the PWM modulator |
| lg_low | input | 1 | Low-side gate voltage is below 1 V |
| zc_trip | input | 1 | Switch-node comparator reports inductor current at or below zero |
| diode_seen | input | 1 | Body-diode conduction was detected on the switch node |
| ls_cmd | output | 1 | Low-side gate command to the driver |
| trim_code | output | TRIM_W | Signed zero-crossing threshold trim, 1 mV per step |

## Verification
The bench builds the block with TIMEOUT_CYC=64, FORCE_CYC=6 and BLANK_CYC=8, with TRIM_W=5 and TRIM_INIT=1 left at their defaults. The short timeout puts watchdog expiry, the exact forced-pulse length and a high-side abort of a forced pulse within a few dozen cycles. It also lets the restart case space its pulses 40 cycles apart, safely under the limit. Each diode-emulated switching cycle takes about fifteen clocks, so the bench can drive the trim code into both of its saturation ends. With the blanking count at eight, a flag that is high only during blanking and low at capture separates the correct capture edge from an edge one cycle early.

// File: rtl/lldem_pkg.sv
package lldem_pkg;

    // Switching-cycle states of the low-side command path
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_CUT,
        ST_FORCE
    } sw_state_t;

    // Sequence used to sample body-diode conduction after a turn-off
    typedef enum logic [1:0] {
        TR_WAIT,
        TR_GATE,
        TR_BLANK,
        TR_CAPT
    } trim_state_t;

endpackage

// File: rtl/lldem_uson_timer.sv
module lldem_uson_timer #(
    parameter int TIMEOUT_CYC = 6400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Expiry is only meaningful once a high-side pulse has been seen
    assign expire = armed_q && !hs_req && (cnt_q == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (hs_req) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lldem_fsm.sv
module lldem_fsm
    import lldem_pkg::*;
#(
    parameter int FORCE_CYC = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hs_req,
    input  logic      ls_req,
    input  logic      zc_trip,
    input  logic      expire,
    output logic      ls_cmd,
    output logic      ls_off_evt,
    output sw_state_t state_o
);
    localparam int FW = $clog2(FORCE_CYC + 1);

    sw_state_t     state_q, state_d;
    logic [FW-1:0] fcnt_q;
    logic          force_done;

    assign force_done = (fcnt_q == FW'(FORCE_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hs_req)      state_d = ST_HIGH;
                else if (expire) state_d = ST_FORCE;
                else if (ls_req) state_d = ST_LOW;
            end
            ST_HIGH: begin
                if (!hs_req) state_d = ls_req ? ST_LOW : ST_IDLE;
            end
            ST_LOW: begin
                if (hs_req)       state_d = ST_HIGH;
                else if (zc_trip) state_d = ST_CUT;
                else if (!ls_req) state_d = ST_IDLE;
            end
            ST_CUT: begin
                if (hs_req)       state_d = ST_HIGH;
                else if (expire)  state_d = ST_FORCE;
                else if (!ls_req) state_d = ST_IDLE;
            end
            ST_FORCE: begin
                if (hs_req)          state_d = ST_HIGH;
                else if (force_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FORCE && state_d == ST_FORCE) fcnt_q <= fcnt_q + 1'b1;
            else                                            fcnt_q <= '0;
        end
    end

    always_comb begin
        ls_cmd     = (state_q == ST_LOW) || (state_q == ST_FORCE);
        ls_off_evt = (state_q == ST_LOW) && (state_d != ST_LOW);
        state_o    = state_q;
    end
endmodule

// File: rtl/lldem_trim.sv
module lldem_trim
    import lldem_pkg::*;
#(
    parameter int TRIM_W    = 5,
    parameter int TRIM_INIT = 1,
    parameter int BLANK_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ls_off_evt,
    input  logic                     lg_low,
    input  logic                     diode_seen,
    output logic signed [TRIM_W-1:0] trim_code
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic signed [TRIM_W-1:0] T_MAX  = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic signed [TRIM_W-1:0] T_MIN  = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic signed [TRIM_W-1:0] T_INIT = TRIM_W'(TRIM_INIT);
    localparam logic signed [TRIM_W-1:0] T_ONE  = TRIM_W'(1);

    trim_state_t             tst_q, tst_d;
    logic [BW-1:0]           bcnt_q;
    logic signed [TRIM_W-1:0] trim_q;

    always_comb begin
        tst_d = tst_q;
        if (ls_off_evt) begin
            tst_d = TR_GATE;
        end else begin
            unique case (tst_q)
                TR_WAIT:  tst_d = TR_WAIT;
                TR_GATE:  if (lg_low) tst_d = TR_BLANK;
                TR_BLANK: if (bcnt_q == BW'(BLANK_CYC - 1)) tst_d = TR_CAPT;
                TR_CAPT:  tst_d = TR_WAIT;
                default:  tst_d = TR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst_q  <= TR_WAIT;
            bcnt_q <= '0;
            trim_q <= T_INIT;
        end else begin
            tst_q <= tst_d;
            if (tst_q == TR_BLANK && tst_d == TR_BLANK) bcnt_q <= bcnt_q + 1'b1;
            else                                        bcnt_q <= '0;
            if (tst_q == TR_CAPT) begin
                if (diode_seen) begin
                    if (trim_q != T_MAX) trim_q <= trim_q + T_ONE;
                end else begin
                    if (trim_q != T_MIN) trim_q <= trim_q - T_ONE;
                end
            end
        end
    end

    assign trim_code = trim_q;
endmodule

// File: rtl/lldem_ctrl.sv
module lldem_ctrl
    import lldem_pkg::*;
#(
    parameter int TIMEOUT_CYC = 6400,
    parameter int FORCE_CYC   = 200,
    parameter int BLANK_CYC   = 8,
    parameter int TRIM_W      = 5,
    parameter int TRIM_INIT   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hs_req,
    input  logic                     ls_req,
    input  logic                     lg_low,
    input  logic                     zc_trip,
    input  logic                     diode_seen,
    output logic                     ls_cmd,
    output logic signed [TRIM_W-1:0] trim_code
);
    logic      expire;
    logic      ls_off_evt;
    sw_state_t fsm_st;

    lldem_uson_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_req (hs_req),
        .expire (expire)
    );

    lldem_fsm #(.FORCE_CYC(FORCE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_req     (hs_req),
        .ls_req     (ls_req),
        .zc_trip    (zc_trip),
        .expire     (expire),
        .ls_cmd     (ls_cmd),
        .ls_off_evt (ls_off_evt),
        .state_o    (fsm_st)
    );

    lldem_trim #(
        .TRIM_W    (TRIM_W),
        .TRIM_INIT (TRIM_INIT),
        .BLANK_CYC (BLANK_CYC)
    ) u_trim (
        .clk        (clk),
        .rst_n      (rst_n),
        .ls_off_evt (ls_off_evt),
        .lg_low     (lg_low),
        .diode_seen (diode_seen),
        .trim_code  (trim_code)
    );
endmodule

// File: rtl/lldem_ctrl_chk.sv
module lldem_ctrl_chk
    import lldem_pkg::*;
#(
    parameter int FORCE_CYC = 200,
    parameter int TRIM_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hs_req,
    input logic                     zc_trip,
    input logic                     ls_cmd,
    input logic signed [TRIM_W-1:0] trim_code,
    input sw_state_t                st
);
    localparam logic signed [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic signed [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};

    int unsigned fc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)               fc_q <= 0;
        else if (st == ST_FORCE)  fc_q <= fc_q + 1;
        else                      fc_q <= 0;
    end

    AST_HS_BLOCKS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |=> !ls_cmd); // R2

    AST_ZC_CUTS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW && zc_trip) |=> !ls_cmd); // R4

    AST_FORCE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FORCE) |-> (fc_q < FORCE_CYC)); // R6

    AST_FORCE_HS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FORCE && hs_req) |=> (st == ST_HIGH)); // R7

    AST_TRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code != $past(trim_code)) |->
        ((trim_code == $past(trim_code) + 1) || (trim_code == $past(trim_code) - 1))); // R9

    AST_TRIM_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code == T_MAX) |=> (trim_code != T_MIN)); // R11

    AST_TRIM_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code == T_MIN) |=> (trim_code != T_MAX)); // R11
endmodule

bind lldem_ctrl lldem_ctrl_chk #(
    .FORCE_CYC (FORCE_CYC),
    .TRIM_W    (TRIM_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_req    (hs_req),
    .zc_trip   (zc_trip),
    .ls_cmd    (ls_cmd),
    .trim_code (trim_code),
    .st        (fsm_st)
);

// File: tb/lldem_ctrl_tb_top.sv
module lldem_ctrl_tb_top;
    localparam int TO  = 64;
    localparam int FC  = 6;
    localparam int BC  = 8;
    localparam int TW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0, lg_low = 1'b0, zc_trip = 1'b0, diode_seen = 1'b0;
    logic ls_cmd;
    logic signed [TW-1:0] trim_code;

    int n_checks = 0;
    int n_errors = 0;
    int exp_trim = 1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lldem_ctrl #(
        .TIMEOUT_CYC (TO),
        .FORCE_CYC   (FC),
        .BLANK_CYC   (BC),
        .TRIM_W      (TW),
        .TRIM_INIT   (1)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_req     (hs_req),
        .ls_req     (ls_req),
        .lg_low     (lg_low),
        .zc_trip    (zc_trip),
        .diode_seen (diode_seen),
        .ls_cmd     (ls_cmd),
        .trim_code  (trim_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hs_pulse();
        @(negedge clk);
        hs_req = 1'b1; ls_req = 1'b0; zc_trip = 1'b0; lg_low = 1'b0; diode_seen = 1'b0;
        @(negedge clk);
        hs_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(ls_cmd == 1'b0, "R1 ls_cmd", int'(ls_cmd), 0);
        check(trim_code == 5'sd1, "R1 trim", int'(trim_code), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_no_arm();
        int highs = 0;
        for (int i = 0; i < TO + 20; i++) begin
            @(negedge clk);
            if (ls_cmd) highs++;
        end
        check(highs == 0, "R12 no force before first hs", highs, 0);
    endtask

    task automatic t_follow();
        @(negedge clk);
        hs_req = 1'b1; ls_req = 1'b1;
        @(negedge clk);
        check(ls_cmd == 1'b0, "R2 hs blocks ls", int'(ls_cmd), 0);
        hs_req = 1'b0;
        @(negedge clk);
        check(ls_cmd == 1'b1, "R3 ls follows rise", int'(ls_cmd), 1);
        @(negedge clk);
        check(ls_cmd == 1'b1, "R3 ls held", int'(ls_cmd), 1);
        ls_req = 1'b0;
        @(negedge clk);
        check(ls_cmd == 1'b0, "R3 ls follows fall", int'(ls_cmd), 0);
    endtask

    // One diode-emulated cycle; blank_v is driven during blanking, capt_v at capture
    task automatic do_cycle(input bit blank_v, input bit capt_v);
        @(negedge clk);
        hs_req = 1'b1; ls_req = 1'b0; lg_low = 1'b0; zc_trip = 1'b0; diode_seen = 1'b0;
        @(negedge clk);
        @(negedge clk);
        hs_req = 1'b0; ls_req = 1'b1;
        @(negedge clk);
        check(ls_cmd == 1'b1, "R3 ls on after hs", int'(ls_cmd), 1);
        @(negedge clk);
        zc_trip = 1'b1;
        @(negedge clk);
        check(ls_cmd == 1'b0, "R4 zero crossing cuts ls", int'(ls_cmd), 0);
        zc_trip = 1'b0; lg_low = 1'b1; diode_seen = blank_v;
        repeat (BC + 1) @(negedge clk);
        diode_seen = capt_v;
        @(negedge clk);
        if (capt_v) exp_trim = (exp_trim < 15) ? exp_trim + 1 : 15;
        else        exp_trim = (exp_trim > -16) ? exp_trim - 1 : -16;
        check(int'(trim_code) == exp_trim, "R9 R10 R11 trim after capture", int'(trim_code), exp_trim);
        check(ls_cmd == 1'b0, "R4 ls stays cut", int'(ls_cmd), 0);
        diode_seen = 1'b0; lg_low = 1'b0;
    endtask

    task automatic t_trim_basic();
        do_cycle(1'b0, 1'b1);   // R9 step up
        do_cycle(1'b1, 1'b0);   // R10 blanked high flag ignored, step down
        do_cycle(1'b0, 1'b0);   // R9 step down
        do_cycle(1'b1, 1'b1);
    endtask

    task automatic t_trim_sat();
        for (int i = 0; i < 20; i++) do_cycle(1'b0, 1'b1);
        check(trim_code == 5'sd15, "R11 upper saturation", int'(trim_code), 15);
        for (int i = 0; i < 36; i++) do_cycle(1'b1, 1'b0);
        check(trim_code == -5'sd16, "R11 lower saturation", int'(trim_code), -16);
    endtask

    task automatic t_timer();
        int first = -1;
        int hc = 1;
        hs_pulse();
        for (int k = 1; k <= TO + 5; k++) begin
            @(negedge clk);
            if (ls_cmd) begin first = k; break; end
        end
        check(first == TO, "R5 forced pulse after timeout", first, TO);
        zc_trip = 1'b1;
        for (int k = 0; k < FC + 5; k++) begin
            @(negedge clk);
            if (ls_cmd) hc++;
            else break;
        end
        zc_trip = 1'b0;
        check(hc == FC, "R6 forced pulse length, zc ignored", hc, FC);
    endtask

    task automatic t_force_abort();
        int first = -1;
        hs_pulse();
        for (int k = 1; k <= TO + 5; k++) begin
            @(negedge clk);
            if (ls_cmd) begin first = k; break; end
        end
        check(first == TO, "R5 forced pulse again", first, TO);
        @(negedge clk);
        hs_req = 1'b1;
        @(negedge clk);
        check(ls_cmd == 1'b0, "R7 hs ends forced pulse", int'(ls_cmd), 0);
        hs_req = 1'b0;
    endtask

    task automatic t_restart();
        int highs = 0;
        for (int r = 0; r < 5; r++) begin
            hs_pulse();
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (ls_cmd) highs++;
            end
        end
        check(highs == 0, "R8 hs pulses restart watchdog", highs, 0);
    endtask

    initial begin
        t_reset();
        t_no_arm();
        t_follow();
        t_trim_basic();
        t_trim_sat();
        t_timer();
        t_force_abort();
        t_restart();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule